// File: doc/BRIEF.md
# ACPI power-management event controller

The block is a byte-wide register file for power-management events. Single-cycle pulses from a timer, a global-lock source, a power button, an alarm, a switch-off source and up to eight generic wake lines land in sticky status bits. A status bit whose matching enable bit is set drives a level-sensitive system control interrupt (SCI). An enabled alarm also drives a power-on control output.

Software puts the system into suspend by writing the sleep-enable bit. While the system is suspended, any enabled wake event sets a wake-status flag. A switch-off pulse sets that flag even when the power-button enable is off. Once the flag is set, the first access to any register in the map ends the suspend state. All registers are reached over a simple valid/write-enable bus with a combinational read path.

Top module: `pm_event_ctrl`

## Requirements
- R1: After the active-low reset, every status bit, enable bit and generic-enable bit reads 0. Both `sci_o` and `power_on_o` are 0, and the system is not suspended.
- R2: Offset 2 is the low enable byte. Bit 0 is the timer enable and bit 5 is the global-lock enable. All other bits of this byte read 0.
- R3: Offset 3 is the high enable byte. Bit 0 is the power-button enable and bit 2 is the alarm enable. All other bits of this byte read 0.
- R4: An event pulse sets its status bit whether or not it is enabled. Offset 0 holds timer status in bit 0 and global-lock status in bit 5. Offset 1 holds power-button status in bit 0, alarm status in bit 2 and wake status in bit 7. All other bits of both bytes read 0.
- R5: Writing 1 to a status bit position clears that bit, and writing 0 leaves it unchanged. For the timer, global-lock, power-button and alarm bits, a set pulse arriving in the same cycle as a clear leaves the bit at 1.
- R6: `sci_o` is high while any of these four status bits is 1 together with its enable. It falls in the cycle after the last such bit is cleared or disabled.
- R7: `power_on_o` is high exactly while the alarm status and the alarm enable are both 1.
- R8: Writing a byte with bit 5 set to offset 4 (control) enters suspend. Offset 4 reads 0.
- R9: Wake status (offset 1, bit 7) is set only while the system is suspended. It is set by an enabled power-button pulse, by an enabled alarm pulse, by a switch-off pulse regardless of any enable, or by a generic wake line whose generic-enable bit is 1. Timer and global-lock pulses never set it.
- R10: A write of 1 to wake status in the same cycle as a wake event leaves wake status at 0.
- R11: While wake status is 1, the first read or write to any offset from 0 to 5 ends suspend. After that, wake events no longer set wake status.
- R12: Offset 5 is an 8-bit read/write generic-enable register. Bit n masks generic wake line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| valid_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| tmr_evt_i | input | 1 | Timer event pulse |
| glock_evt_i | input | 1 | Global-lock event pulse |
| pwrbtn_evt_i | input | 1 | Power-button event pulse |
| alarm_evt_i | input | 1 | Alarm event pulse |
| swoff_evt_i | input | 1 | Switch-off event pulse |
| gp_wake_i | input | GP_W | Generic wake event pulses |
| sci_o | output | 1 | System control interrupt, level |
| power_on_o | output | 1 | Power-on control |

## Verification
The hardest state to reach is a suspended system whose exit is still pending. Suspend has no output of its own, so it can only be seen by whether a later wake event sets wake status. Any read of wake status with the flag already at 1 ends the suspend being probed. The stimulus therefore collides a wake-status clear with a switch-off pulse inside suspend, which leaves the flag at 0 and keeps the system suspended. A second switch-off pulse then shows that suspend survived, and a final clear-then-pulse sequence shows that it ended. A behavioural model in the bench follows every cycle and is compared against the interrupt, power-on and read-data outputs.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned OFS_STS_LO = 0;
  localparam int unsigned OFS_STS_HI = 1;
  localparam int unsigned OFS_EN_LO  = 2;
  localparam int unsigned OFS_EN_HI  = 3;
  localparam int unsigned OFS_CTL    = 4;
  localparam int unsigned OFS_GP_EN  = 5;
  localparam int unsigned OFS_LAST   = OFS_GP_EN;

  localparam int unsigned B_TMR = 0;
  localparam int unsigned B_GBL = 5;
  localparam int unsigned B_PWR = 0;
  localparam int unsigned B_ALM = 2;
  localparam int unsigned B_WAK = 7;
  localparam int unsigned B_SLP = 5;

  // status slot order inside the status vector
  localparam int unsigned S_TMR = 0;
  localparam int unsigned S_GBL = 1;
  localparam int unsigned S_PWR = 2;
  localparam int unsigned S_ALM = 3;
  localparam int unsigned N_STS = 4;
endpackage

// File: rtl/pm_sts_bit.sv
module pm_sts_bit #(
  parameter bit CLEAR_WINS = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic nxt;

  generate
    if (CLEAR_WINS) begin : g_clr_pri
      assign nxt = clr_i ? 1'b0 : (set_i | q_o);
    end else begin : g_set_pri
      assign nxt = set_i | (q_o & ~clr_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= nxt;
  end

  generate
    if (CLEAR_WINS) begin : g_a_clr
      a_r10_clear_beats_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !q_o);
    end else begin : g_a_set
      a_r5_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> q_o);
      a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !set_i) |=> !q_o);
    end
  endgenerate
endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_wr_i,
  input  logic pm_access_i,
  input  logic wake_evt_i,
  input  logic wake_clr_i,
  output logic wake_o
);
  logic suspend_q;

  pm_sts_bit #(.CLEAR_WINS(1'b1)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (suspend_q & wake_evt_i),
    .clr_i (wake_clr_i),
    .q_o   (wake_o)
  );

  // entering sleep outranks the exit caused by the same access
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   suspend_q <= 1'b0;
    else if (sleep_wr_i)           suspend_q <= 1'b1;
    else if (pm_access_i && wake_o) suspend_q <= 1'b0;
  end

  a_r8_sleep_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_wr_i |=> suspend_q);
  a_r9_wake_only_suspended: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(suspend_q));
  a_r11_access_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_access_i && wake_o && !sleep_wr_i) |=> !suspend_q);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
  import pm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned GP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              tmr_evt_i,
  input  logic              glock_evt_i,
  input  logic              pwrbtn_evt_i,
  input  logic              alarm_evt_i,
  input  logic              swoff_evt_i,
  input  logic [GP_W-1:0]   gp_wake_i,
  output logic              sci_o,
  output logic              power_on_o
);
  localparam logic [ADDR_W-1:0] A_STS_LO = ADDR_W'(OFS_STS_LO);
  localparam logic [ADDR_W-1:0] A_STS_HI = ADDR_W'(OFS_STS_HI);
  localparam logic [ADDR_W-1:0] A_EN_LO  = ADDR_W'(OFS_EN_LO);
  localparam logic [ADDR_W-1:0] A_EN_HI  = ADDR_W'(OFS_EN_HI);
  localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFS_CTL);
  localparam logic [ADDR_W-1:0] A_GP_EN  = ADDR_W'(OFS_GP_EN);
  localparam logic [ADDR_W-1:0] A_LAST   = ADDR_W'(OFS_LAST);

  logic             wr, pm_access;
  logic [N_STS-1:0] sts_set, sts_clr, sts_q, en_q;
  logic [GP_W-1:0]  gp_en_q;
  logic             wake_q, wake_evt, sleep_wr, wake_clr;

  assign wr        = valid_i & we_i;
  assign pm_access = valid_i & (addr_i <= A_LAST);

  assign sts_set[S_TMR] = tmr_evt_i;
  assign sts_set[S_GBL] = glock_evt_i;
  assign sts_set[S_PWR] = pwrbtn_evt_i;
  assign sts_set[S_ALM] = alarm_evt_i;

  assign sts_clr[S_TMR] = wr && addr_i == A_STS_LO && wdata_i[B_TMR];
  assign sts_clr[S_GBL] = wr && addr_i == A_STS_LO && wdata_i[B_GBL];
  assign sts_clr[S_PWR] = wr && addr_i == A_STS_HI && wdata_i[B_PWR];
  assign sts_clr[S_ALM] = wr && addr_i == A_STS_HI && wdata_i[B_ALM];
  assign wake_clr       = wr && addr_i == A_STS_HI && wdata_i[B_WAK];
  assign sleep_wr       = wr && addr_i == A_CTL    && wdata_i[B_SLP];

  generate
    for (genvar i = 0; i < N_STS; i++) begin : g_sts
      pm_sts_bit #(.CLEAR_WINS(1'b0)) u_bit (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (sts_set[i]),
        .clr_i (sts_clr[i]),
        .q_o   (sts_q[i])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      gp_en_q <= '0;
    end else if (wr) begin
      if (addr_i == A_EN_LO) begin
        en_q[S_TMR] <= wdata_i[B_TMR];
        en_q[S_GBL] <= wdata_i[B_GBL];
      end
      if (addr_i == A_EN_HI) begin
        en_q[S_PWR] <= wdata_i[B_PWR];
        en_q[S_ALM] <= wdata_i[B_ALM];
      end
      if (addr_i == A_GP_EN) gp_en_q <= wdata_i[GP_W-1:0];
    end
  end

  // switch-off bypasses every enable
  assign wake_evt = (pwrbtn_evt_i & en_q[S_PWR]) | (alarm_evt_i & en_q[S_ALM]) |
                    swoff_evt_i | (|(gp_wake_i & gp_en_q));

  pm_wake_ctrl u_wake (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_wr_i (sleep_wr),
    .pm_access_i(pm_access),
    .wake_evt_i (wake_evt),
    .wake_clr_i (wake_clr),
    .wake_o     (wake_q)
  );

  assign sci_o      = |(sts_q & en_q);
  assign power_on_o = sts_q[S_ALM] & en_q[S_ALM];

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_STS_LO: begin
        rdata_o[B_TMR] = sts_q[S_TMR];
        rdata_o[B_GBL] = sts_q[S_GBL];
      end
      A_STS_HI: begin
        rdata_o[B_PWR] = sts_q[S_PWR];
        rdata_o[B_ALM] = sts_q[S_ALM];
        rdata_o[B_WAK] = wake_q;
      end
      A_EN_LO: begin
        rdata_o[B_TMR] = en_q[S_TMR];
        rdata_o[B_GBL] = en_q[S_GBL];
      end
      A_EN_HI: begin
        rdata_o[B_PWR] = en_q[S_PWR];
        rdata_o[B_ALM] = en_q[S_ALM];
      end
      A_GP_EN: rdata_o[GP_W-1:0] = gp_en_q;
      default: rdata_o = '0;
    endcase
  end

  a_r6_no_enable_no_sci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !sci_o);
  a_r7_power_on_with_sci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_on_o |-> sci_o);
  a_r3_reserved_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !we_i && addr_i == A_EN_HI) |-> (rdata_o[7:3] == 5'd0 && !rdata_o[1]));
  a_r8_ctl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i == A_CTL) |-> rdata_o == 8'd0);
endmodule

// File: tb/tb_pm_event_ctrl.sv
module tb_pm_event_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_v = 1'b0, b_we = 1'b0;
  logic [2:0] b_a = '0;
  logic [7:0] b_d = '0;
  logic [4:0] b_ev = '0;   // 0 tmr, 1 gbl, 2 pwr, 3 alm, 4 swoff
  logic [7:0] b_gp = '0;
  logic [7:0] rdata;
  logic       sci, pon;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pm_event_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(b_v), .we_i(b_we), .addr_i(b_a),
    .wdata_i(b_d), .rdata_o(rdata), .tmr_evt_i(b_ev[0]), .glock_evt_i(b_ev[1]),
    .pwrbtn_evt_i(b_ev[2]), .alarm_evt_i(b_ev[3]), .swoff_evt_i(b_ev[4]),
    .gp_wake_i(b_gp), .sci_o(sci), .power_on_o(pon)
  );

  // behavioural reference
  bit m_tmr, m_gbl, m_pwr, m_alm, m_wak, m_susp;
  bit e_tmr, e_gbl, e_pwr, e_alm;
  bit [7:0] m_gp;

  function automatic bit [7:0] m_read(int a);
    case (a)
      0: return {2'b00, m_gbl, 4'b0000, m_tmr};
      1: return {m_wak, 4'b0000, m_alm, 1'b0, m_pwr};
      2: return {2'b00, e_gbl, 4'b0000, e_tmr};
      3: return {5'b00000, e_alm, 1'b0, e_pwr};
      5: return m_gp;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_tmr, m_gbl, m_pwr, m_alm, m_wak, m_susp} = '0;
      {e_tmr, e_gbl, e_pwr, e_alm} = '0;
      m_gp = '0;
    end else begin
      automatic bit w   = b_v && b_we;
      automatic bit acc = b_v && b_a <= 3'd5;
      automatic bit ev  = (b_ev[2] && e_pwr) || (b_ev[3] && e_alm) || b_ev[4] || ((b_gp & m_gp) != 0);
      automatic bit n_wak, n_susp;
      n_wak  = (w && b_a == 1 && b_d[7]) ? 1'b0 : ((m_susp && ev) ? 1'b1 : m_wak);
      n_susp = (w && b_a == 4 && b_d[5]) ? 1'b1 : ((acc && m_wak) ? 1'b0 : m_susp);
      m_tmr = b_ev[0] || (m_tmr && !(w && b_a == 0 && b_d[0]));
      m_gbl = b_ev[1] || (m_gbl && !(w && b_a == 0 && b_d[5]));
      m_pwr = b_ev[2] || (m_pwr && !(w && b_a == 1 && b_d[0]));
      m_alm = b_ev[3] || (m_alm && !(w && b_a == 1 && b_d[2]));
      if (w && b_a == 2) begin e_tmr = b_d[0]; e_gbl = b_d[5]; end
      if (w && b_a == 3) begin e_pwr = b_d[0]; e_alm = b_d[2]; end
      if (w && b_a == 5) m_gp = b_d;
      m_wak  = n_wak;
      m_susp = n_susp;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit we, input int a, input int d, input int ev, input int gp);
    automatic bit exp_sci, exp_pon;
    @(negedge clk);
    exp_sci = (m_tmr && e_tmr) || (m_gbl && e_gbl) || (m_pwr && e_pwr) || (m_alm && e_alm);
    exp_pon = m_alm && e_alm;
    chk(sci == exp_sci, "R6", "sci vs model", sci, exp_sci);
    chk(pon == exp_pon, "R7", "power_on vs model", pon, exp_pon);
    b_v = v; b_we = we; b_a = 3'(a); b_d = 8'(d); b_ev = 5'(ev); b_gp = 8'(gp);
    #1;
    if (v && !we) chk(rdata == m_read(a), "R4", "rdata vs model", rdata, m_read(a));
  endtask

  task automatic idle();         cyc(0, 0, 0, 0, 0, 0);   endtask
  task automatic wr(input int a, input int d); cyc(1, 1, a, d, 0, 0); endtask
  task automatic pulse(input int ev, input int gp); cyc(0, 0, 0, 0, ev, gp); endtask
  task automatic rd(input int a, input int exp, input string tag);
    cyc(1, 0, a, 0, 0, 0);
    chk(rdata == 8'(exp), tag, $sformatf("read offset %0d", a), rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk(sci == 0, "R1", "sci after reset", sci, 0);
    chk(pon == 0, "R1", "power_on after reset", pon, 0);
    for (int a = 0; a < 6; a++) rd(a, 0, "R1");
    // R2 R3 R12 enable layouts
    wr(2, 8'hFF); rd(2, 8'h21, "R2");
    wr(3, 8'hFF); rd(3, 8'h05, "R3");
    wr(5, 8'hA5); rd(5, 8'hA5, "R12");
    wr(2, 0); wr(3, 0);
    // R4 set without enable, R6 sci
    pulse(5'h01, 0); rd(0, 8'h01, "R4");
    chk(sci == 0, "R6", "sci with enable off", sci, 0);
    wr(2, 8'h01); idle();
    chk(sci == 1, "R6", "sci with enable on", sci, 1);
    wr(0, 8'h00); rd(0, 8'h01, "R5");
    wr(0, 8'h01); idle();
    chk(sci == 0, "R6", "sci after clear", sci, 0);
    rd(0, 0, "R5");
    // R5 set beats clear
    cyc(1, 1, 0, 8'h21, 5'h03, 0); rd(0, 8'h21, "R5");
    wr(0, 8'h21); rd(0, 0, "R5");
    // R7 alarm
    wr(3, 8'h04); pulse(5'h08, 0); idle();
    chk(pon == 1, "R7", "power_on on enabled alarm", pon, 1);
    rd(1, 8'h04, "R4");
    wr(1, 8'h04); idle();
    chk(pon == 0, "R7", "power_on after clear", pon, 0);
    // R9 nothing outside suspend
    pulse(5'h04, 0); rd(1, 8'h01, "R4");
    wr(1, 8'h01);
    pulse(5'h10, 0); rd(1, 0, "R9");
    // R8 suspend, R9 disabled button, switch-off
    wr(4, 8'h20); rd(4, 0, "R8");
    pulse(5'h04, 0); rd(1, 8'h01, "R9");
    pulse(5'h10, 0); rd(1, 8'h81, "R9");
    wr(1, 8'h81);
    pulse(5'h10, 0); rd(1, 0, "R11");
    // R10 clear beats wake; suspend survives
    wr(4, 8'h20);
    cyc(1, 1, 1, 8'h80, 5'h10, 0); rd(1, 0, "R10");
    pulse(5'h10, 0); rd(1, 8'h80, "R10");
    wr(1, 8'h80);
    pulse(5'h10, 0); rd(1, 0, "R11");
    // R9 generic mask (A5)
    wr(4, 8'h20);
    pulse(0, 8'h02); rd(1, 0, "R12");
    pulse(0, 8'h04); rd(1, 8'h80, "R9");
    wr(1, 8'h80);
    // R9 enabled alarm wake
    wr(4, 8'h20); pulse(5'h08, 0); idle();
    chk(pon == 1, "R7", "power_on on alarm wake", pon, 1);
    rd(1, 8'h84, "R9");
    wr(1, 8'h84); idle();
    // R9 timer and global lock do not wake
    wr(2, 8'h21); wr(4, 8'h20);
    pulse(5'h03, 0); rd(1, 0, "R9");
    rd(0, 8'h21, "R4"); idle();
    chk(sci == 1, "R6", "sci from timer and lock", sci, 1);
    wr(0, 8'h21); idle(); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule